// File: doc/BRIEF.md
# Regulator Protection and Hiccup Sequencer

This block decides, cycle by cycle, whether a buck converter's power stage may switch, whether it must pull its output to ground, and when the output ramp controller has to start a fresh soft start. It watches four conditions: the enable input, a comparator flag for input undervoltage (which already has hysteresis), a comparator flag for over-current, and a digitised junction temperature.

The four conditions have a fixed priority. Enable low wins over undervoltage, undervoltage wins over over-temperature, and over-temperature wins over over-current. A condition with higher priority cuts short any sequence of lower priority that is in progress. An over-current event does not shut the converter down for good. The high-side switch turns off and the low-side switch turns on for a hold of 1 ms, counted in clock cycles. A full soft start follows, and this hiccup loop repeats for as long as the fault persists. Over-temperature has a hysteresis band: once tripped, the output stays off until the temperature has dropped by the band width. The block always leaves an idle or fault state through soft start, and it reaches the running state only after the ramp controller reports that the ramp is done. A sticky counter records how many over-current events have occurred.

Top module: `regProtSeq`

## Requirements
- R1: While reset is asserted, and right after it, every output is low: switchEn, forceLow, softStartReq, the three status flags, and hiccupCount at 0.
- R2: enable low has the highest priority. One clock edge after enable is low, switchEn, forceLow, softStartReq and statHiccup are all 0, even in the middle of a hiccup hold.
- R3: When enable is high and uvFlag is high, one edge later switchEn and forceLow are 0 and statUv is 1. Over-current and temperature have no effect while this holds.
- R4: A tempCode strictly above TRIP_TEMP (150) turns switching off and sets statThermal two edges later. A tempCode of exactly 150 does not trip.
- R5: After a thermal trip, switching stays off until tempCode is at or below TRIP_TEMP-HYST_DEG (135). The trip stays remembered while a higher-priority undervoltage interrupts it. After the temperature has fallen to 135, soft start begins two edges later.
- R6: An over-current flag seen during soft start or run sets forceLow=1, switchEn=0 and statHiccup=1 one edge later.
- R7: The pull-low hold lasts exactly CLK_KHZ cycles (1 ms), and ocFlag is ignored for its whole length.
- R8: At the end of the hold, softStartReq and switchEn rise with forceLow low. If ocFlag is still high, the hold-and-restart cycle repeats without limit.
- R9: Every exit from shutdown, undervoltage, thermal or hiccup goes through soft start (softStartReq=1, switchEn=1). The block enters run (switchEn=1, softStartReq=0) only on the edge after rampDone is high.
- R10: hiccupCount rises by exactly one on each entry into the pull-low hold, saturates at 2^CNT_W-1, and is cleared only by reset. It keeps its value through enable low.
- R11: switchEn and forceLow are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter enable, high permits start-up |
| uvFlag | input | 1 | Input undervoltage comparator output, high means too low |
| ocFlag | input | 1 | High-side over-current comparator output |
| tempCode | input | TEMP_W | Junction temperature in degrees C, unsigned |
| rampDone | input | 1 | Ramp controller reports the soft-start ramp is complete |
| switchEn | output | 1 | Power stage may switch |
| forceLow | output | 1 | High-side off, low-side on (output pull-down) |
| softStartReq | output | 1 | Request to the ramp controller to run a soft start |
| statUv | output | 1 | Held off by undervoltage |
| statThermal | output | 1 | Held off by over-temperature |
| statHiccup | output | 1 | In the over-current pull-low hold |
| hiccupCount | output | CNT_W | Sticky, saturating count of over-current events |

## Verification
The assertions check on every cycle that the following hold: the pull-down and switching never overlap, enable low and undervoltage force the stage off one edge later, a reading above the trip point leads to switching off, switching can only rise together with a soft-start request, and the event counter moves by at most one per cycle. The bench scenarios cover the properties that span many cycles: the exact length of the 1 ms hold, over-current being ignored inside it, the repeated hiccup loop, counter saturation, and the thermal band including the 150 and 135 boundaries and the trip surviving an undervoltage interruption. These need long input histories that a simple per-cycle property cannot follow.

// File: rtl/regProtPkg.sv
package regProtPkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_UVLO   = 3'd1,
    ST_HOT    = 3'd2,
    ST_HICCUP = 3'd3,
    ST_RAMP   = 3'd4,
    ST_RUN    = 3'd5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hiccupEvt;  // entering the pull-low hold this edge
    logic holdRun;    // currently inside the pull-low hold
  } seqStrobe_t;

endpackage

// File: rtl/regProtCtrl.sv
module regProtCtrl
  import regProtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       uvFlag,
  input  logic       ocFlag,
  input  logic       rampDone,
  input  logic       hotLatched,
  input  logic       holdDone,
  output seqStrobe_t strobe,
  output logic       switchEn,
  output logic       forceLow,
  output logic       softStartReq,
  output logic       statUv,
  output logic       statThermal,
  output logic       statHiccup
);

  seqState_t curState;
  seqState_t nxtState;

  // priority first, then per-state progress
  always_comb begin
    nxtState = curState;
    if (!enable) begin
      nxtState = ST_OFF;
    end else if (uvFlag) begin
      nxtState = ST_UVLO;
    end else if (hotLatched) begin
      nxtState = ST_HOT;
    end else begin
      case (curState)
        ST_OFF, ST_UVLO, ST_HOT: nxtState = ST_RAMP;
        ST_HICCUP: if (holdDone) nxtState = ST_RAMP;
        ST_RAMP: begin
          if (ocFlag)        nxtState = ST_HICCUP;
          else if (rampDone) nxtState = ST_RUN;
        end
        ST_RUN: if (ocFlag) nxtState = ST_HICCUP;
        default: nxtState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OFF;
    else       curState <= nxtState;
  end

  always_comb begin
    strobe.hiccupEvt = (nxtState == ST_HICCUP) && (curState != ST_HICCUP);
    strobe.holdRun   = (curState == ST_HICCUP);
  end

  // Moore outputs
  always_comb begin
    switchEn     = (curState == ST_RAMP) || (curState == ST_RUN);
    forceLow     = (curState == ST_HICCUP);
    softStartReq = (curState == ST_RAMP);
    statUv       = (curState == ST_UVLO);
    statThermal  = (curState == ST_HOT);
    statHiccup   = (curState == ST_HICCUP);
  end

endmodule

// File: rtl/regProtDatapath.sv
module regProtDatapath
  import regProtPkg::*;
#(
  parameter int HOLD_CYCLES = 250000,
  parameter int TEMP_W      = 8,
  parameter int TRIP_TEMP   = 150,
  parameter int HYST_DEG    = 15,
  parameter int CNT_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  seqStrobe_t        strobe,
  output logic              hotLatched,
  output logic              holdDone,
  output logic [CNT_W-1:0]  hiccupCount
);

  localparam int HOLD_W     = $clog2(HOLD_CYCLES + 1);
  localparam int CLEAR_TEMP = TRIP_TEMP - HYST_DEG;
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [TEMP_W-1:0] TRIP_CODE  = TEMP_W'(TRIP_TEMP);
  localparam logic [TEMP_W-1:0] CLEAR_CODE = TEMP_W'(CLEAR_TEMP);

  logic [HOLD_W-1:0] holdCnt;

  // pull-low hold timer: loaded on entry, counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.hiccupEvt) begin
      holdCnt <= HOLD_LOAD;
    end else if (strobe.holdRun && (holdCnt != '0)) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign holdDone = (holdCnt == '0);

  // thermal trip with hysteresis band
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hotLatched <= 1'b0;
    end else if (tempCode > TRIP_CODE) begin
      hotLatched <= 1'b1;
    end else if (tempCode <= CLEAR_CODE) begin
      hotLatched <= 1'b0;
    end
  end

  // sticky saturating event counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiccupCount <= '0;
    end else if (strobe.hiccupEvt && (hiccupCount != '1)) begin
      hiccupCount <= hiccupCount + 1'b1;
    end
  end

endmodule

// File: rtl/regProtSeq.sv
module regProtSeq
  import regProtPkg::*;
#(
  parameter int CLK_KHZ   = 250000,
  parameter int TEMP_W    = 8,
  parameter int TRIP_TEMP = 150,
  parameter int HYST_DEG  = 15,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              uvFlag,
  input  logic              ocFlag,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic              rampDone,
  output logic              switchEn,
  output logic              forceLow,
  output logic              softStartReq,
  output logic              statUv,
  output logic              statThermal,
  output logic              statHiccup,
  output logic [CNT_W-1:0]  hiccupCount
);

  // 1 ms expressed in clock cycles
  localparam int HOLD_CYCLES = CLK_KHZ;

  seqStrobe_t strobe;
  logic       hotLatched;
  logic       holdDone;

  regProtCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .uvFlag       (uvFlag),
    .ocFlag       (ocFlag),
    .rampDone     (rampDone),
    .hotLatched   (hotLatched),
    .holdDone     (holdDone),
    .strobe       (strobe),
    .switchEn     (switchEn),
    .forceLow     (forceLow),
    .softStartReq (softStartReq),
    .statUv       (statUv),
    .statThermal  (statThermal),
    .statHiccup   (statHiccup)
  );

  regProtDatapath #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .TEMP_W      (TEMP_W),
    .TRIP_TEMP   (TRIP_TEMP),
    .HYST_DEG    (HYST_DEG),
    .CNT_W       (CNT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tempCode    (tempCode),
    .strobe      (strobe),
    .hotLatched  (hotLatched),
    .holdDone    (holdDone),
    .hiccupCount (hiccupCount)
  );

endmodule

// File: rtl/regProtSeqChecker.sv
module regProtSeqChecker #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_TEMP = 150,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              uvFlag,
  input logic [TEMP_W-1:0] tempCode,
  input logic              switchEn,
  input logic              forceLow,
  input logic              softStartReq,
  input logic              statUv,
  input logic              statHiccup,
  input logic [CNT_W-1:0]  hiccupCount
);

  localparam logic [TEMP_W-1:0] TRIP_LIM = TEMP_W'(TRIP_TEMP);

  AST_STAGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(switchEn && forceLow)); // R11

  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!switchEn && !forceLow && !softStartReq && !statHiccup)); // R2

  AST_UV_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (enable && uvFlag) |=> (!switchEn && !forceLow && statUv)); // R3

  AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(tempCode > TRIP_LIM)) |=> !switchEn); // R4

  AST_RAMP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchEn) |-> softStartReq); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((hiccupCount == $past(hiccupCount)) ||
              (hiccupCount == $past(hiccupCount) + CNT_W'(1)))); // R10

  AST_HOLD_COUNTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceLow) |-> (hiccupCount != '0)); // R6

endmodule

bind regProtSeq regProtSeqChecker #(
  .TEMP_W    (TEMP_W),
  .TRIP_TEMP (TRIP_TEMP),
  .CNT_W     (CNT_W)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .uvFlag       (uvFlag),
  .tempCode     (tempCode),
  .switchEn     (switchEn),
  .forceLow     (forceLow),
  .softStartReq (softStartReq),
  .statUv       (statUv),
  .statHiccup   (statHiccup),
  .hiccupCount  (hiccupCount)
);

// File: tb/test_regProtSeq.sv
`timescale 1ns/1ps
module test_regProtSeq;

  localparam int CLK_KHZ = 20;   // hold = 20 cycles
  localparam int TEMP_W  = 8;
  localparam int CNT_W   = 2;
  localparam int HOLD    = CLK_KHZ;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, uvFlag = 1'b0, ocFlag = 1'b0, rampDone = 1'b0;
  logic [TEMP_W-1:0] tempCode = 8'd25;
  logic switchEn, forceLow, softStartReq, statUv, statThermal, statHiccup;
  logic [CNT_W-1:0] hiccupCount;

  always #2 clk = ~clk;

  regProtSeq #(.CLK_KHZ(CLK_KHZ), .TEMP_W(TEMP_W), .TRIP_TEMP(150),
               .HYST_DEG(15), .CNT_W(CNT_W)) i_regProtSeq (
    .clk(clk), .rstN(rstN), .enable(enable), .uvFlag(uvFlag),
    .ocFlag(ocFlag), .tempCode(tempCode), .rampDone(rampDone),
    .switchEn(switchEn), .forceLow(forceLow), .softStartReq(softStartReq),
    .statUv(statUv), .statThermal(statThermal), .statHiccup(statHiccup),
    .hiccupCount(hiccupCount)
  );

  typedef struct {
    string      req;
    logic [7:0] vec;
  } expItem_t;

  expItem_t scoreQ[$];
  int  checks = 0;
  int  failures = 0;
  bit  overlapSeen = 1'b0;
  bit  stimDone = 1'b0;

  function automatic logic [7:0] mk(logic sw, logic fl, logic ss, logic uv,
                                    logic th, logic hc, logic [1:0] cnt);
    return {sw, fl, ss, uv, th, hc, cnt};
  endfunction

  task automatic expectNow(string req, logic [7:0] v);
    expItem_t it;
    it.req = req;
    it.vec = v;
    scoreQ.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pops expected items away from the clock edge and compares
  always @(negedge clk) begin
    logic [7:0] act;
    act = {switchEn, forceLow, softStartReq, statUv, statThermal,
           statHiccup, hiccupCount};
    if (switchEn && forceLow) overlapSeen = 1'b1;
    while (scoreQ.size() > 0) begin
      expItem_t it;
      it = scoreQ.pop_front();
      checks++;
      if (act !== it.vec) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b (sw fl ss uv th hc cnt)",
                 it.req, act, it.vec);
      end
    end
  end

  initial begin
    step(3);
    expectNow("R1 in reset", mk(0,0,0,0,0,0,2'd0));
    rstN = 1'b1;
    step(1);
    expectNow("R1 after reset, enable low", mk(0,0,0,0,0,0,2'd0));

    // start-up through soft start
    enable = 1'b1;
    step(1);
    expectNow("R9 start goes to soft start", mk(1,0,1,0,0,0,2'd0));
    step(3);
    expectNow("R9 waits for ramp done", mk(1,0,1,0,0,0,2'd0));
    rampDone = 1'b1;
    step(1);
    expectNow("R9 run after ramp done", mk(1,0,0,0,0,0,2'd0));
    rampDone = 1'b0;

    // over-current hiccup; ocFlag held high throughout
    ocFlag = 1'b1;
    step(1);
    expectNow("R6 over-current pulls low", mk(0,1,0,0,0,1,2'd1));
    step(HOLD - 2);
    expectNow("R7 oc ignored during hold", mk(0,1,0,0,0,1,2'd1));
    step(1);
    expectNow("R7 hold last cycle", mk(0,1,0,0,0,1,2'd1));
    step(1);
    expectNow("R8 restart after hold", mk(1,0,1,0,0,0,2'd1));
    step(1);
    expectNow("R8 repeat hiccup", mk(0,1,0,0,0,1,2'd2));
    step(HOLD + 1);
    expectNow("R10 count third event", mk(0,1,0,0,0,1,2'd3));
    step(HOLD + 1);
    expectNow("R10 count saturates", mk(0,1,0,0,0,1,2'd3));
    ocFlag = 1'b0;
    step(HOLD);
    expectNow("R9 hiccup exits via soft start", mk(1,0,1,0,0,0,2'd3));
    rampDone = 1'b1;
    step(1);
    rampDone = 1'b0;
    expectNow("R9 run again", mk(1,0,0,0,0,0,2'd3));

    // undervoltage beats over-current and temperature
    uvFlag = 1'b1; ocFlag = 1'b1; tempCode = 8'd160;
    step(1);
    expectNow("R3 undervoltage priority", mk(0,0,0,1,0,0,2'd3));
    step(2);
    expectNow("R3 oc and hot ignored in undervoltage", mk(0,0,0,1,0,0,2'd3));
    ocFlag = 1'b0; tempCode = 8'd25;
    step(2);
    uvFlag = 1'b0;
    step(1);
    expectNow("R9 undervoltage exits via soft start", mk(1,0,1,0,0,0,2'd3));
    rampDone = 1'b1;
    step(1);
    rampDone = 1'b0;

    // thermal boundaries
    tempCode = 8'd150;
    step(3);
    expectNow("R4 150 does not trip", mk(1,0,0,0,0,0,2'd3));
    tempCode = 8'd151;
    step(2);
    expectNow("R4 151 trips", mk(0,0,0,0,1,0,2'd3));
    tempCode = 8'd140;
    step(4);
    expectNow("R5 inside band stays off", mk(0,0,0,0,1,0,2'd3));
    uvFlag = 1'b1;
    step(1);
    expectNow("R3 undervoltage over thermal", mk(0,0,0,1,0,0,2'd3));
    uvFlag = 1'b0;
    step(1);
    expectNow("R5 trip remembered after undervoltage", mk(0,0,0,0,1,0,2'd3));
    tempCode = 8'd136;
    step(3);
    expectNow("R5 136 still off", mk(0,0,0,0,1,0,2'd3));
    tempCode = 8'd135;
    step(2);
    expectNow("R5 135 recovers via soft start", mk(1,0,1,0,0,0,2'd3));
    rampDone = 1'b1;
    step(1);
    rampDone = 1'b0;

    // enable low aborts a hiccup hold, counter sticky
    ocFlag = 1'b1;
    step(1);
    expectNow("R6 oc from run", mk(0,1,0,0,0,1,2'd3));
    ocFlag = 1'b0;
    step(3);
    enable = 1'b0;
    step(1);
    expectNow("R2 enable low aborts hold", mk(0,0,0,0,0,0,2'd3));
    step(2);
    expectNow("R10 count kept in shutdown", mk(0,0,0,0,0,0,2'd3));
    enable = 1'b1;
    step(1);
    expectNow("R9 shutdown exits via soft start", mk(1,0,1,0,0,0,2'd3));
    step(2);

    checks++;
    if (overlapSeen) begin
      failures++;
      $display("FAIL R11 overlap actual=1 expected=0");
    end
    stimDone = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (stimDone) break;
    end
    if (!stimDone) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule